// File: doc/BRIEF.md
# Pipeline Hazard Unit

This block decides, in the same cycle, how a five-stage integer pipeline (fetch, decode, execute, memory, write-back) copes with conflicts between the instructions it holds. For each of the two ALU operands of the instruction in execute, it picks where the operand comes from. The choices are the register file, the result waiting in the execute/memory register, or the result waiting in the memory/write-back register.

The block also raises one freeze signal. That signal holds the program counter and the fetch/decode register, and it loads a no-op control word into the decode/execute register. The freeze is raised in three cases:

- a load in execute produces a value that the instruction in decode needs;
- a conditional branch sits in decode and its outcome is not yet known;
- the instruction in decode would meet a long-latency result at the single register-file write port.

The block is purely combinational from inputs to outputs. The clock and reset feed only the checks embedded in the RTL.

Top module: `hazard_unit`

## Requirements
- R1: When the instruction in the execute/memory register writes a nonzero register equal to the first execute source, `fwdSelA` is 2 (execute/memory result), even if the memory/write-back register also matches.
- R2: When only the memory/write-back register writes a nonzero register equal to a live execute source, that source's select is 1. With no match, the select is 0 (register file).
- R3: The second execute source is live only when `exOpcode` is 0x00 (register-register). For any other opcode, `fwdSelB` is 0. For opcode 0x00, it follows the same rules as `fwdSelA`.
- R4: Register 0 never forwards and never causes a load-use freeze: a source or destination of 0 never matches.
- R5: A load in execute (`exOpcode` from 0x20 to 0x27, `exRegWrite` high) whose nonzero `exRd` equals `idRs1` causes a freeze. If `idOpcode` is 0x00, an `exRd` equal to `idRs2` also causes a freeze; for any other `idOpcode`, `idRs2` is ignored.
- R6: A decode opcode of 0x04, 0x05, 0x06 or 0x07 (conditional branch) causes a freeze while `branchResolved` is low. It causes no freeze once `branchResolved` is high.
- R7: When `idRegWrite` and `lateWrClaim` are both high, the block freezes, because the two writes would share one port.
- R8: `stallFetch` and `bubbleEx` are always equal: every freeze of the fetch side inserts a bubble.
- R9: When none of R5, R6 or R7 applies, `stallFetch` and `bubbleEx` are low. This includes the state with all inputs at zero, during and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the embedded checks |
| rstN | input | 1 | Active-low reset, disables the embedded checks |
| idOpcode | input | 6 | Primary opcode of the instruction in decode |
| idRs1 | input | 5 | First source register in decode |
| idRs2 | input | 5 | Second source register in decode |
| idRegWrite | input | 1 | Decode instruction will write the register file |
| exOpcode | input | 6 | Primary opcode of the instruction in execute |
| exRs1 | input | 5 | First source register in execute |
| exRs2 | input | 5 | Second source register in execute |
| exRd | input | 5 | Destination register in execute |
| exRegWrite | input | 1 | Execute instruction writes the register file |
| memRd | input | 5 | Destination in the execute/memory register |
| memRegWrite | input | 1 | Execute/memory instruction writes the register file |
| wbRd | input | 5 | Destination in the memory/write-back register |
| wbRegWrite | input | 1 | Memory/write-back instruction writes the register file |
| branchResolved | input | 1 | Outcome of the branch in decode is known |
| lateWrClaim | input | 1 | A long-latency unit claims the write port in the slot the decode instruction would use |
| fwdSelA | output | 2 | Operand A source: 0 register file, 1 write-back stage, 2 memory stage |
| fwdSelB | output | 2 | Operand B source, same encoding |
| stallFetch | output | 1 | Hold the PC and the fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into the decode/execute register |

## Verification
Several rules are checked on every cycle by the embedded properties. These are the priority of the younger result, the silence of operand B for single-source opcodes, the exclusion of register 0, the coupling of freeze and bubble, and the freeze on an open branch or a port clash. What those properties cannot show is that no freeze or forward appears when none is due, across the interplay of opcodes and register numbers. The bench sweeps register numbers 0 to 3 against a set of opcodes, write enables and branch states to show it. The sweep also covers the decode second-source rule and the load opcode range boundaries, which only exhaustive stimulus reaches.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  localparam int OPC_W   = 6;
  localparam int NUM_SRC = 2;

  localparam logic [OPC_W-1:0] OPC_REGREG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BR_LO   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BR_HI   = 6'h07;
  localparam logic [OPC_W-1:0] OPC_LD_LO   = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LD_HI   = 6'h27;

  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwdSel_e;

  // strobes passed from the comparator path to the freeze control
  typedef struct packed {
    logic loadUseHit;
    logic portClash;
    logic branchOpen;
  } hazStrobe_t;

  function automatic logic readsTwoSrc(input logic [OPC_W-1:0] opc);
    return opc == OPC_REGREG;
  endfunction

  function automatic logic isLoadOpc(input logic [OPC_W-1:0] opc);
    return (opc >= OPC_LD_LO) && (opc <= OPC_LD_HI);
  endfunction

  function automatic logic isCondBranch(input logic [OPC_W-1:0] opc);
    return (opc >= OPC_BR_LO) && (opc <= OPC_BR_HI);
  endfunction

endpackage

// File: rtl/hazard_fwd_path.sv
module hazard_fwd_path
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] idOpcode,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic [OPC_W-1:0] exOpcode,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             loadUseHit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0][REG_W-1:0] exSrc;
  logic [NUM_SRC-1:0][REG_W-1:0] idSrc;
  logic [NUM_SRC-1:0]            exLive;
  logic [NUM_SRC-1:0]            idLive;
  logic [NUM_SRC-1:0][1:0]       selBus;
  logic [NUM_SRC-1:0]            idHit;
  logic                          memValid;
  logic                          wbValid;
  logic                          exLoadValid;

  assign exSrc[0]  = exRs1;
  assign exSrc[1]  = exRs2;
  assign idSrc[0]  = idRs1;
  assign idSrc[1]  = idRs2;
  assign exLive[0] = 1'b1;
  assign exLive[1] = readsTwoSrc(exOpcode);
  assign idLive[0] = 1'b1;
  assign idLive[1] = readsTwoSrc(idOpcode);

  assign memValid    = memRegWrite && (memRd != ZERO_REG);
  assign wbValid     = wbRegWrite && (wbRd != ZERO_REG);
  assign exLoadValid = isLoadOpc(exOpcode) && exRegWrite && (exRd != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic srcOk;
    assign srcOk = exLive[g] && (exSrc[g] != ZERO_REG);
    // the younger execute/memory result outranks the write-back one
    assign selBus[g] = (srcOk && memValid && (memRd == exSrc[g])) ? FWD_MEM :
                       (srcOk && wbValid  && (wbRd  == exSrc[g])) ? FWD_WB  :
                                                                     FWD_NONE;
    assign idHit[g]  = idLive[g] && exLoadValid && (exRd == idSrc[g]);
  end

  assign fwdSelA    = selBus[0];
  assign fwdSelB    = selBus[1];
  assign loadUseHit = |idHit;

  p_younger_wins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd == exRs1 && exRs1 != ZERO_REG) |-> fwdSelA == FWD_MEM);

  p_wb_fallback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wbRegWrite && wbRd == exRs1 && exRs1 != ZERO_REG &&
     !(memRegWrite && memRd == exRs1)) |-> fwdSelA == FWD_WB);

  p_src_b_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (exOpcode != OPC_REGREG) |-> fwdSelB == FWD_NONE);

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (exRs1 == ZERO_REG) |-> (fwdSelA == FWD_NONE));

  p_zero_dest_r4: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == ZERO_REG) |-> !loadUseHit);

  p_load_use_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isLoadOpc(exOpcode) && exRegWrite && exRd != ZERO_REG && exRd == idRs1)
      |-> loadUseHit);

endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hazard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] idOpcode,
  input  logic             idRegWrite,
  input  logic             branchResolved,
  input  logic             lateWrClaim,
  input  logic             loadUseHit,
  output logic             stallFetch,
  output logic             bubbleEx
);

  hazStrobe_t strobes;
  logic       freeze;

  always_comb begin
    strobes            = '0;
    strobes.loadUseHit = loadUseHit;
    strobes.portClash  = idRegWrite && lateWrClaim;
    strobes.branchOpen = isCondBranch(idOpcode) && !branchResolved;
  end

  assign freeze     = |strobes;
  assign stallFetch = freeze;
  assign bubbleEx   = freeze;

  p_branch_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isCondBranch(idOpcode) && !branchResolved) |-> stallFetch);

  p_port_clash_r7: assert property (@(posedge clk) disable iff (!rstN)
    (idRegWrite && lateWrClaim) |-> (stallFetch && bubbleEx));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!loadUseHit && !(idRegWrite && lateWrClaim) &&
     !(isCondBranch(idOpcode) && !branchResolved)) |-> !stallFetch);

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] idOpcode,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idRegWrite,
  input  logic [OPC_W-1:0] exOpcode,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic             branchResolved,
  input  logic             lateWrClaim,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             stallFetch,
  output logic             bubbleEx
);

  logic loadUseHit;

  hazard_fwd_path #(.REG_W(REG_W)) fwdPath_i (
    .clk        (clk),
    .rstN       (rstN),
    .idOpcode   (idOpcode),
    .idRs1      (idRs1),
    .idRs2      (idRs2),
    .exOpcode   (exOpcode),
    .exRs1      (exRs1),
    .exRs2      (exRs2),
    .exRd       (exRd),
    .exRegWrite (exRegWrite),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .fwdSelA    (fwdSelA),
    .fwdSelB    (fwdSelB),
    .loadUseHit (loadUseHit)
  );

  hazard_stall_ctrl stallCtrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .idOpcode      (idOpcode),
    .idRegWrite    (idRegWrite),
    .branchResolved(branchResolved),
    .lateWrClaim   (lateWrClaim),
    .loadUseHit    (loadUseHit),
    .stallFetch    (stallFetch),
    .bubbleEx      (bubbleEx)
  );

  p_freeze_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    stallFetch == bubbleEx);

endmodule

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] idOpcode = '0;
  logic [4:0] idRs1 = '0;
  logic [4:0] idRs2 = '0;
  logic       idRegWrite = 1'b0;
  logic [5:0] exOpcode = '0;
  logic [4:0] exRs1 = '0;
  logic [4:0] exRs2 = '0;
  logic [4:0] exRd = '0;
  logic       exRegWrite = 1'b0;
  logic [4:0] memRd = '0;
  logic       memRegWrite = 1'b0;
  logic [4:0] wbRd = '0;
  logic       wbRegWrite = 1'b0;
  logic       branchResolved = 1'b0;
  logic       lateWrClaim = 1'b0;
  logic [1:0] fwdSelA;
  logic [1:0] fwdSelB;
  logic       stallFetch;
  logic       bubbleEx;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hazard_unit dut_i (
    .clk(clk), .rstN(rstN),
    .idOpcode(idOpcode), .idRs1(idRs1), .idRs2(idRs2), .idRegWrite(idRegWrite),
    .exOpcode(exOpcode), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exRegWrite(exRegWrite), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .branchResolved(branchResolved),
    .lateWrClaim(lateWrClaim), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFetch(stallFetch), .bubbleEx(bubbleEx)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int expSel(input int src, input bit live, input int md, input bit mw,
                                input int wd, input bit ww);
    if (!live || src == 0) return 0;
    if (mw && md != 0 && md == src) return 2;
    if (ww && wd != 0 && wd == src) return 1;
    return 0;
  endfunction

  // one combination per cycle: drive after the falling edge, sample 2 ns later
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1500000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stimulus
    logic [5:0] exOps [6];
    logic [5:0] idOps [8];
    exOps = '{6'h00, 6'h08, 6'h1f, 6'h20, 6'h23, 6'h27};
    idOps = '{6'h00, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h28};

    repeat (2) @(negedge clk);
    #2;
    // R9: reset state with all-zero inputs
    check("R9 reset stall", int'(stallFetch), 0);
    check("R9 reset bubble", int'(bubbleEx), 0);
    check("R9 reset fwdA", int'(fwdSelA), 0);
    check("R9 reset fwdB", int'(fwdSelB), 0);
    rstN = 1'b1;

    // forwarding sweep: R1, R2, R3, R4
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++) for (int w = 0; w < 4; w++)
      for (int en = 0; en < 4; en++) begin
        int eA;
        int eB;
        settle();
        exOpcode = (op == 0) ? 6'h00 : 6'h08;
        exRs1 = 5'(a); exRs2 = 5'(b); memRd = 5'(m); wbRd = 5'(w);
        memRegWrite = en[0]; wbRegWrite = en[1];
        #2;
        eA = expSel(a, 1'b1, m, en[0], w, en[1]);
        eB = expSel(b, op == 0, m, en[0], w, en[1]);
        if (a == 0) check("R4 fwdA zero src", int'(fwdSelA), eA);
        else if (eA == 2) check("R1 fwdA mem priority", int'(fwdSelA), eA);
        else check("R2 fwdA wb or none", int'(fwdSelA), eA);
        if (op != 0) check("R3 fwdB single source", int'(fwdSelB), eB);
        else if (b == 0) check("R4 fwdB zero src", int'(fwdSelB), eB);
        else check("R3 fwdB reg-reg", int'(fwdSelB), eB);
      end
    end

    // freeze sweep: R4, R5, R6, R7, R8, R9
    exRs1 = '0; exRs2 = '0; memRegWrite = 1'b0; wbRegWrite = 1'b0;
    for (int xo = 0; xo < 6; xo++) for (int io = 0; io < 8; io++)
    for (int r1 = 0; r1 < 4; r1++) for (int r2 = 0; r2 < 4; r2++)
    for (int rd = 0; rd < 4; rd++) for (int fl = 0; fl < 16; fl++) begin
      bit ld;
      bit br;
      bit cl;
      int exp;
      settle();
      exOpcode = exOps[xo]; idOpcode = idOps[io];
      idRs1 = 5'(r1); idRs2 = 5'(r2); exRd = 5'(rd);
      exRegWrite = fl[0]; branchResolved = fl[1];
      idRegWrite = fl[2]; lateWrClaim = fl[3];
      #2;
      ld = (exOps[xo] >= 6'h20) && (exOps[xo] <= 6'h27) && fl[0] && rd != 0 &&
           (rd == r1 || (idOps[io] == 6'h00 && rd == r2));
      br = (idOps[io] >= 6'h04) && (idOps[io] <= 6'h07) && !fl[1];
      cl = fl[2] && fl[3];
      exp = (ld || br || cl) ? 1 : 0;
      if (cl) check("R7 port clash", int'(stallFetch), exp);
      else if (br) check("R6 open branch", int'(stallFetch), exp);
      else if (ld) check("R5 load use", int'(stallFetch), exp);
      else if (rd == 0) check("R4 zero dest", int'(stallFetch), exp);
      else check("R9 no freeze", int'(stallFetch), exp);
      check("R8 bubble pairs stall", int'(bubbleEx), exp);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule